// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned operands one bit per clock. It uses one full adder and one carry flip-flop. Each operand sits in its own register. The registers can be loaded in parallel and shifted right. A load pulse copies both operands in and clears the carry. A start pulse then begins the shift phase, which lasts exactly WIDTH clocks (4 by default).

On every shift clock the full adder combines three bits: the lowest bit of the first register, the lowest bit of the second register and the stored carry. The sum bit enters the first register at its top. The second register takes in a zero at its top, and the carry out is stored. When the shift phase ends, the first register holds the sum, the carry flip-flop holds the final carry and a done flag pulses for one clock. The result stays in place until the next load or start.

Top module: `serial_adder4`

## Requirements
- R1: After reset, sum_o is 0, carry_o is 0 and done_o is 0.
- R2: A load_i sampled while the block is idle makes sum_o equal to opa_i on the next clock. The operand from opb_i is kept for the addition.
- R3: A start_i sampled while idle, with load_i low, begins an addition. done_o is high only during the cycle that follows the WIDTH-th rising edge after the edge that sampled start_i. It is high for exactly one cycle.
- R4: While done_o is high, sum_o equals (A + B) mod 2^WIDTH and carry_o equals bit WIDTH of A + B. Here A and B are the loaded operands.
- R5: A load clears the carry flip-flop, so carry_o is 0 on the cycle after the load. A carry left over from an earlier addition never enters the next one.
- R6: A start_i pulse during the shift phase is ignored. done_o keeps its original timing, no second done_o follows, and the result is unchanged.
- R7: A load_i pulse during the shift phase is ignored. The result equals the sum of the operands loaded before start.
- R8: When load_i and start_i are both high in one idle cycle, the load takes effect and the start is ignored. No done_o follows, and sum_o keeps the loaded operand.
- R9: After done_o, sum_o and carry_o hold their values until the next load or start. During each shift the second register takes in a zero at its top. So a start with no new load adds carry_o into sum_o, for example 0 with carry 1 gives 1 with carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Parallel load of both operands, clears the carry |
| start_i | input | 1 | Begin the WIDTH-cycle serial addition |
| opa_i | input | WIDTH | First operand, also the result register |
| opb_i | input | WIDTH | Second operand |
| sum_o | output | WIDTH | Contents of the first register (the sum once done) |
| carry_o | output | 1 | Stored carry (the final carry once done) |
| done_o | output | 1 | One-cycle pulse when the addition ends |

## Verification
The operand pairs are chosen to tell apart specific adder faults. 3+5 needs a carry to ripple across bits. 15+1 and 15+15 generate a carry on every step, and they must leave a final carry of 1. 10+5 produces no carry at any step, so a stuck-at-one carry shows up. A pair that leaves carry 1 is followed by a load of 2+3. That sequence shows whether the load clears the carry. A start with no reload checks two things: that the second register takes in zeros, and that the held carry is added. Pulses of start or load during the shift phase, and a start that arrives together with a load, show whether the control logic ignores them as required.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

    typedef struct packed {
        logic sum;
        logic cout;
    } fa_out_t;

endpackage

// File: rtl/sa_full_adder.sv
module sa_full_adder
    import serial_add_pkg::*;
(
    input  logic    a_i,
    input  logic    b_i,
    input  logic    cin_i,
    output fa_out_t res_o
);
    always_comb begin
        res_o.sum  = a_i ^ b_i ^ cin_i;
        res_o.cout = (a_i & b_i) | (a_i & cin_i) | (b_i & cin_i);
    end
endmodule

// File: rtl/sa_shift_reg.sv
module sa_shift_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ser_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (load_i)
            q_d = par_i;
        else if (shift_i)
            q_d = {ser_i, q_q[WIDTH-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q_o = q_q;

    assert_load_copies_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> q_q == $past(par_i));

    assert_shift_right_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && shift_i) |=> q_q == {$past(ser_i), $past(q_q[WIDTH-1:1])});

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !shift_i) |=> $stable(q_q));
endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl #(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic start_i,
    output logic load_ok_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.cnt  = '0;
            end
        end else if (start_i && !load_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign load_ok_o = load_i && !s_q.busy;
    assign busy_o    = s_q.busy;
    assign done_o    = s_q.done;

    assert_done_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    assert_ends_after_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt == LAST) |=> (s_q.done && !s_q.busy));

    assert_start_begins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && start_i && !load_i) |=> (s_q.busy && s_q.cnt == '0));

    assert_start_with_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && start_i && load_i) |=> (!s_q.busy && !s_q.done));

    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != LAST && start_i) |=>
            (s_q.busy && s_q.cnt == $past(s_q.cnt) + CNT_W'(1)));
endmodule

// File: rtl/serial_adder4.sv
module serial_adder4
    import serial_add_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             start_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             done_o
);
    logic             load_ok, busy;
    logic [WIDTH-1:0] a_q, b_q;
    fa_out_t          fa;
    logic             carry_d, carry_q;

    sa_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .start_i  (start_i),
        .load_ok_o(load_ok),
        .busy_o   (busy),
        .done_o   (done_o)
    );

    sa_shift_reg #(.WIDTH(WIDTH)) u_reg_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_ok),
        .shift_i(busy),
        .par_i  (opa_i),
        .ser_i  (fa.sum),
        .q_o    (a_q)
    );

    sa_shift_reg #(.WIDTH(WIDTH)) u_reg_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_ok),
        .shift_i(busy),
        .par_i  (opb_i),
        .ser_i  (1'b0),
        .q_o    (b_q)
    );

    sa_full_adder u_fa (
        .a_i  (a_q[0]),
        .b_i  (b_q[0]),
        .cin_i(carry_q),
        .res_o(fa)
    );

    always_comb begin
        carry_d = carry_q;
        if (load_ok)
            carry_d = 1'b0;
        else if (busy)
            carry_d = fa.cout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) carry_q <= 1'b0;
        else        carry_q <= carry_d;
    end

    assign sum_o   = a_q;
    assign carry_o = carry_q;

    assert_load_clears_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_ok |=> (carry_q == 1'b0 && a_q == $past(opa_i)));

    assert_busy_load_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load_i) |=> a_q == {$past(fa.sum), $past(a_q[WIDTH-1:1])});

    assert_idle_carry_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load_i) |=> $stable(carry_q));
endmodule

// File: tb/sim_serial_adder4.sv
module sim_serial_adder4;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0, start_i = 1'b0;
    logic [W-1:0] opa_i = '0, opb_i = '0;
    logic [W-1:0] sum_o;
    logic         carry_o, done_o;

    int errors = 0;
    int checks = 0;
    logic [W:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_adder4 #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i),
        .opa_i(opa_i), .opb_i(opb_i), .sum_o(sum_o), .carry_o(carry_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: every done pulse pops one expected {carry,sum} (R4)
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R6", "unexpected done", 1, 0);
            end else begin
                logic [W:0] e;
                e = expq.pop_front();
                chk({carry_o, sum_o} == e, "R4", "sum/carry at done", {carry_o, sum_o}, e);
            end
        end
    end

    task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        load_i = 1'b1; opa_i = a; opb_i = b;
        @(negedge clk);
        load_i = 1'b0;
        chk(sum_o == a, "R2", "sum_o after load", sum_o, a);
        chk(carry_o == 1'b0, "R5", "carry_o after load", carry_o, 0);
    endtask

    // mode 0 plain, 1 start pulse mid-run (R6), 2 load pulse mid-run (R7)
    task automatic run(input logic [W:0] exp, input int mode, input string req);
        expq.push_back(exp);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 1; i <= W; i++) begin
            @(negedge clk);
            chk(done_o == (i == W), req, "done timing", done_o, (i == W));
            if (i == 2 && mode == 1) start_i = 1'b1;
            if (i == 2 && mode == 2) begin load_i = 1'b1; opa_i = '1; opb_i = '1; end
            if (i == 3) begin start_i = 1'b0; load_i = 1'b0; end
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R3", "done one cycle", done_o, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sum_o == 0, "R1", "sum_o reset", sum_o, 0);
        chk(carry_o == 0, "R1", "carry_o reset", carry_o, 0);
        chk(done_o == 0, "R1", "done_o reset", done_o, 0);

        do_load(4'd3, 4'd5);   run(5'd8, 0, "R3");
        do_load(4'd15, 4'd1);  run({1'b1, 4'd0}, 0, "R3");
        // R9: start without reload adds held carry, B now zero
        run({1'b0, 4'd1}, 0, "R9");
        begin
            logic [W-1:0] held;
            held = sum_o;
            repeat (3) @(negedge clk);
            chk(sum_o == held, "R9", "sum_o held after done", sum_o, held);
            chk(carry_o == 1'b0, "R9", "carry_o held after done", carry_o, 0);
        end
        do_load(4'd9, 4'd9);   run({1'b1, 4'd2}, 0, "R3");
        // R5: carry 1 left over, load must clear it
        do_load(4'd2, 4'd3);   run(5'd5, 0, "R5");
        do_load(4'd10, 4'd5);  run(5'd15, 0, "R3");
        do_load(4'd15, 4'd15); run({1'b1, 4'd14}, 0, "R3");
        do_load(4'd6, 4'd7);   run(5'd13, 1, "R6");
        do_load(4'd4, 4'd4);   run(5'd8, 2, "R7");
        do_load(4'd0, 4'd0);   run(5'd0, 0, "R3");

        // R8: load and start together, start ignored
        @(negedge clk);
        load_i = 1'b1; start_i = 1'b1; opa_i = 4'd1; opb_i = 4'd2;
        @(negedge clk);
        load_i = 1'b0; start_i = 1'b0;
        for (int i = 0; i < W + 2; i++) begin
            chk(done_o == 1'b0, "R8", "no done after load+start", done_o, 0);
            @(negedge clk);
        end
        chk(sum_o == 4'd1, "R8", "sum_o keeps loaded operand", sum_o, 1);
        chk(expq.size() == 0, "R4", "pending results", expq.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule